// File: doc/BRIEF.md
# Parallel NRZI Serial-Video Descrambler

This block recovers video words from a serial line that is first scrambled with a self-synchronizing x^9 + x^4 + 1 scrambler and then NRZI-encoded. It takes one parallel slice of raw line bits per clock. A slice holds 10 bits in standard-definition mode and 20 bits in high-definition mode. Bit 0 is always the earliest bit on the line.

Within each clock, the block converts the whole slice from NRZI to NRZ and then undoes the scrambling. It keeps the last line bit and the last nine NRZ bits, so the next slice continues exactly where the previous one ended. Nothing runs at the serial bit rate.

The block sits after a deserializer that has already done word alignment and clock recovery. Any reset or change of mode clears the carried history. The slice that follows such an event is then withheld, because it starts from unknown history.

Top module: `nrzi_descrambler`

## Requirements
- R1: While reset is asserted (rst_n low, sampled at the clock edge), the block drives out_vld low and dout to zero.
- R2: Each NRZ bit is the XOR of a line bit and the line bit one position earlier in time. For bit 0, the earlier bit is the last line bit of the previous accepted slice.
- R3: Each output bit is the NRZ bit XOR the NRZ bits 4 and 9 positions earlier in time. Those earlier positions reach back into the previous accepted slice when needed.
- R4: With hd_mode=1, all 20 bits of din form one slice, with din[0] earliest in time. The recovered 20-bit word appears on dout one clock after the slice is accepted.
- R5: With hd_mode=0, only din[9:0] form the slice and din[19:10] are ignored. dout[9:0] carry the word and dout[19:10] are driven to zero.
- R6: out_vld is high only in the cycle after a cycle with in_vld high. When in_vld is low, dout keeps its value in the next cycle.
- R7: Cycles with in_vld low do not disturb the carried history. A slice that follows a gap decodes as if no gap had occurred.
- R8: After reset, the first accepted slice gives out_vld low. Every later slice of a correctly scrambled and encoded stream is recovered exactly.
- R9: When hd_mode differs from its value in the previous cycle, the history is cleared. The next accepted slice gives out_vld low; this is the slice in that same cycle if in_vld is high there. Later slices are recovered exactly in the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | A slice is present on din |
| hd_mode | input | 1 | 1 = 20-bit slices, 0 = 10-bit slices |
| din | input | 20 | Raw line bits, bit 0 earliest |
| out_vld | output | 1 | dout holds a newly recovered word |
| dout | output | 20 | Recovered word |

## Verification
The assertions relate out_vld and dout only to in_vld and hd_mode one cycle earlier. They assume that rst_n, in_vld, hd_mode and din are stable around the rising edge. The bench meets this by changing every input only on the falling clock edge. No property depends on din matching any scrambler, so the bench is free to fill the ignored upper bits in standard-definition mode with noise. Exact recovery is checked separately by a scrambler and NRZI encoder model in the bench that runs bit by bit.

// File: rtl/nrzi_descrambler.sv
module nrzi_descrambler #(
  parameter int SD_W = 10,
  parameter int HD_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic            hd_mode,
  input  logic [HD_W-1:0] din,
  output logic            out_vld,
  output logic [HD_W-1:0] dout
);
  localparam int DEG   = 9;
  localparam int TAP   = 4;
  localparam int EXT_W = HD_W + DEG;

  logic [DEG-1:0]   hist, hist_eff, hist_nx;
  logic             prev_line, prev_eff, prev_nx;
  logic             mode_q, fresh, chg;
  logic [HD_W-1:0]  line_m, nrz, desc, dout_nx;
  logic [EXT_W-1:0] ext;

  assign chg      = hd_mode != mode_q;
  assign hist_eff = chg ? '0 : hist;
  assign prev_eff = chg ? 1'b0 : prev_line;

  assign line_m = hd_mode ? din : {{(HD_W-SD_W){1'b0}}, din[SD_W-1:0]};
  assign nrz    = line_m ^ {line_m[HD_W-2:0], prev_eff};
  assign ext    = {nrz, hist_eff};

  for (genvar i = 0; i < HD_W; i++) begin : g_bit
    assign desc[i] = ext[i+DEG] ^ ext[i+DEG-TAP] ^ ext[i];
  end

  assign dout_nx = hd_mode ? desc : {{(HD_W-SD_W){1'b0}}, desc[SD_W-1:0]};
  assign hist_nx = hd_mode ? ext[HD_W+DEG-1:HD_W] : ext[SD_W+DEG-1:SD_W];
  assign prev_nx = hd_mode ? din[HD_W-1] : din[SD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist      <= '0;
      prev_line <= 1'b0;
      fresh     <= 1'b1;
      mode_q    <= hd_mode;
      out_vld   <= 1'b0;
      dout      <= '0;
    end else begin
      mode_q  <= hd_mode;
      out_vld <= in_vld & ~(fresh | chg);
      if (in_vld) begin
        hist      <= hist_nx;
        prev_line <= prev_nx;
        fresh     <= 1'b0;
        dout      <= dout_nx;
      end else if (chg) begin
        hist      <= '0;
        prev_line <= 1'b0;
        fresh     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nrzi_descrambler_chk.sv
module nrzi_descrambler_chk #(
  parameter int SD_W = 10,
  parameter int HD_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic            hd_mode,
  input logic            out_vld,
  input logic [HD_W-1:0] dout
);
  // R6
  vld_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(dout)));

  // R5
  sd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !hd_mode) |=> (dout[HD_W-1:SD_W] == '0));

  // R9
  mode_switch_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (hd_mode != $past(hd_mode))) |=> !out_vld);
endmodule

bind nrzi_descrambler nrzi_descrambler_chk #(.SD_W(SD_W), .HD_W(HD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .hd_mode(hd_mode),
  .out_vld(out_vld), .dout(dout)
);

// File: tb/sim_nrzi_descrambler.sv
`timescale 1ns/1ps
module sim_nrzi_descrambler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        hd_mode = 1'b1;
  logic [19:0] din = '0;
  logic        out_vld;
  logic [19:0] dout;

  int checks = 0;
  int failures = 0;

  logic [8:0]  enc_sr = '0;
  logic        enc_line = 1'b0;

  localparam logic [19:0] VEC [16] = '{
    20'h00000, 20'hFFFFF, 20'h3FF00, 20'h003FF, 20'hAAAAA, 20'h55555,
    20'h12345, 20'hFEDCB, 20'h80001, 20'h7FFFE, 20'h0F0F0, 20'hF0F0F,
    20'h00200, 20'h3FC00, 20'hC3A5E, 20'h1B7D2
  };

  always #2.5 clk = ~clk;

  nrzi_descrambler u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .hd_mode(hd_mode),
    .din(din), .out_vld(out_vld), .dout(dout)
  );

  function automatic logic [19:0] encode(input logic [19:0] w, input logic hd);
    logic [19:0] line;
    line = '0;
    for (int i = 0; i < (hd ? 20 : 10); i++) begin
      logic scr;
      scr      = w[i] ^ enc_sr[3] ^ enc_sr[8];
      enc_sr   = {enc_sr[7:0], scr};
      enc_line = enc_line ^ scr;
      line[i]  = enc_line;
    end
    if (!hd) line[19:10] = 10'($urandom);
    return line;
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [19:0] w, input logic hd, input logic exp_v, input string tag);
    din     = encode(w, hd);
    hd_mode = hd;
    in_vld  = 1'b1;
    @(negedge clk);
    check({tag, " out_vld"}, {19'b0, out_vld}, {19'b0, exp_v});
    if (exp_v) check({tag, " dout"}, dout, hd ? w : {10'b0, w[9:0]});
  endtask

  task automatic idle(input int n, input logic [19:0] held);
    in_vld = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R6 idle out_vld", {19'b0, out_vld}, 20'h0);
      check("R6 idle dout hold", dout, held);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_vld", {19'b0, out_vld}, 20'h0);
    check("R1 reset dout", dout, 20'h0);
    rst_n = 1'b1;

    push(20'h13579, 1'b1, 1'b0, "R8 first slice muted");
    for (int i = 0; i < 16; i++) push(VEC[i], 1'b1, 1'b1, "R2 R3 R4 hd table");

    idle(3, VEC[15]);
    for (int i = 0; i < 4; i++) push(VEC[i], 1'b1, 1'b1, "R7 after gap");

    push(20'h00155, 1'b0, 1'b0, "R9 switch to sd muted");
    for (int i = 0; i < 16; i++) push(VEC[i], 1'b0, 1'b1, "R5 sd table");
    push(20'h00000, 1'b0, 1'b1, "R5 sd zeros");
    push(20'h003FF, 1'b0, 1'b1, "R5 sd ones");
    idle(2, 20'h003FF);
    push(20'h00201, 1'b0, 1'b1, "R7 sd after gap");

    in_vld  = 1'b0;
    hd_mode = 1'b1;
    @(negedge clk);
    check("R9 idle switch out_vld", {19'b0, out_vld}, 20'h0);
    in_vld = 1'b0;
    @(negedge clk);
    push(20'hABCDE, 1'b1, 1'b0, "R9 first after idle switch muted");
    for (int i = 0; i < 200; i++) push(20'($urandom), 1'b1, 1'b1, "R3 R4 hd random");
    push(20'h00000, 1'b0, 1'b0, "R9 to sd");
    for (int i = 0; i < 100; i++) push(20'($urandom), 1'b0, 1'b1, "R5 sd random");

    rst_n  = 1'b0;
    din    = 20'hFFFFF;
    in_vld = 1'b1;
    @(negedge clk);
    check("R1 mid reset out_vld", {19'b0, out_vld}, 20'h0);
    check("R1 mid reset dout", dout, 20'h0);
    rst_n = 1'b1;
    push(20'h55AA5, 1'b1, 1'b0, "R8 muted after reset");
    push(20'h5A5A5, 1'b1, 1'b1, "R8 recovered after reset");
    push(20'hA5A5A, 1'b1, 1'b1, "R2 R8 continued");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule